// File: doc/BRIEF.md
# Performance Limit Status Logger

This block sits beside a power controller and records when the core's efficiency optimisations are held back. Two live flags come in: one saying an electrical current ceiling is being exceeded, and one saying another hardware domain is limiting this one. Each flag shows live in a status word. Each also has a sticky log copy that hardware sets and only software clears. Software clears a log bit by writing a zero to it.

The block also watches an 8-bit guaranteed-performance value and a single-cycle minimum-excursion pulse. An interrupt-enable word selects which of these events may set a pending flag. The pending flag drives a level interrupt output until software acknowledges it. Software reaches both words through a plain register port. The port has a select bit, a write strobe, write data and a read bus that follows the select combinationally.

Top module: `perf_limit_logger`

## Requirements
- R1: Status word (reg_sel_i = 0) bit 12 equals cur_lim_i and bit 14 equals xdom_lim_i in the same cycle, with no register in the path.
- R2: Status bit 13 is set at the clock edge that samples cur_lim_i high, and it stays set until cleared.
- R3: Status bit 15 is set at the clock edge that samples xdom_lim_i high, and it stays set until cleared.
- R4: A status write with bit 13 (or bit 15) at 0 clears that log bit at the write's edge. Writing 1 leaves the bit unchanged. If the matching limit input is high in the cycle of a clearing write, the log bit ends up set.
- R5: Written values of status bits 12, 14 and all other status bits have no effect. Status bits 11:0 and 63:16 read 0.
- R6: The interrupt-enable word (reg_sel_i = 1) holds bit 0 (enable on guaranteed-performance change) and bit 1 (enable on minimum-excursion pulse). A write loads both bits at the write's edge. Bits 63:2 read 0.
- R7: While enable bit 0 is 1, an edge at which guar_perf_i differs from the value sampled at the previous edge sets the pending flag. irq_o shows the pending flag from the cycle after that edge.
- R8: Changes of guar_perf_i while enable bit 0 is 0 leave irq_o low.
- R9: A min_exc_i pulse sets the pending flag when enable bit 1 is 1, and is ignored when enable bit 1 is 0.
- R10: irq_ack_i high at an edge clears the pending flag. An enabled event at the same edge takes priority, and the flag stays set.
- R11: Pulling rst_n low immediately clears both log bits, both enable bits and the pending flag. Release is synchronised through two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lim_i | input | 1 | Current ceiling exceeded now |
| xdom_lim_i | input | 1 | Another domain limiting this one now |
| guar_perf_i | input | 8 | Guaranteed-performance value |
| min_exc_i | input | 1 | Single-cycle minimum-excursion event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status word, 1 selects interrupt-enable word |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the selected word |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Level interrupt, high while pending |

## Verification
A log flop stuck or wrongly cleared shows on bit 13 or 15 of the status read one edge after the stimulus. Bit 13 and bit 15 are each driven by their own limit input, so a swap between the two logs is exposed by raising one input alone. A wrong copy of the guaranteed-performance value appears as a spurious or missing irq_o level one cycle after a change. A lost priority between an event and an acknowledge shows as irq_o dropping on the very edge where it should hold. Enable bits that were mis-loaded appear directly on the enable-word read after a single write.

// File: rtl/plim_pkg.sv
package plim_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned GPERF_W = 8;
  localparam int unsigned N_LIM   = 2;

  // bit positions in the status word
  localparam int unsigned ST_CUR_LIVE  = 12;
  localparam int unsigned ST_CUR_LOG   = 13;
  localparam int unsigned ST_XDOM_LIVE = 14;
  localparam int unsigned ST_XDOM_LOG  = 15;

  // bit positions in the interrupt-enable word
  localparam int unsigned EN_CHG = 0;
  localparam int unsigned EN_MIN = 1;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_IRQ_EN = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/plim_rst_sync.sv
module plim_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/plim_sticky_log.sv
module plim_sticky_log (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic log_o
);
  logic log_q;
  logic log_d;
  logic log_en;

  assign log_en = set_i | clr_i;

  always_comb begin
    log_d = log_q;
    if (clr_i) log_d = 1'b0;
    if (set_i) log_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      log_q <= 1'b0;
    else if (log_en) log_q <= log_d;
  end

  assign log_o = log_q;

  // R2
  log_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> log_q);

  // R4
  log_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !log_q);

  // R3
  log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (log_q == $past(log_q)));
endmodule

// File: rtl/plim_irq_ctl.sv
module plim_irq_ctl #(
  parameter int unsigned GPERF_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GPERF_W-1:0] gperf_i,
  input  logic               en_chg_i,
  input  logic               en_min_i,
  input  logic               min_exc_i,
  input  logic               ack_i,
  output logic               pend_o
);
  logic [GPERF_W-1:0] prev_q;
  logic               pend_q;
  logic               pend_d;
  logic               chg_evt;
  logic               min_evt;
  logic               any_evt;

  assign chg_evt = en_chg_i && (gperf_i != prev_q);
  assign min_evt = en_min_i && min_exc_i;
  assign any_evt = chg_evt | min_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= gperf_i;
  end

  always_comb begin
    pend_d = pend_q;
    if (ack_i)   pend_d = 1'b0;
    if (any_evt) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (ack_i || any_evt)  pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R7
  chg_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_chg_i && (gperf_i != prev_q)) |=> pend_q);

  // R9
  min_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_min_i && min_exc_i) |=> pend_q);

  // R10
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !chg_evt && !min_evt) |=> !pend_q);

  // R8
  no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !en_chg_i && !en_min_i) |=> !pend_q);
endmodule

// File: rtl/plim_regs.sv
module plim_regs
  import plim_pkg::*;
#(
  parameter int unsigned REG_W = plim_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             cur_live_i,
  input  logic             xdom_live_i,
  input  logic [N_LIM-1:0] log_i,
  output logic [N_LIM-1:0] clr_o,
  output logic             en_chg_o,
  output logic             en_min_o,
  output logic [REG_W-1:0] rdata_o
);
  reg_sel_e   sel;
  logic [1:0] en_q;
  logic [1:0] en_d;
  logic       en_we;
  logic       st_we;

  assign sel   = reg_sel_e'(sel_i);
  assign en_we = wr_i && (sel == SEL_IRQ_EN);
  assign st_we = wr_i && (sel == SEL_STATUS);

  assign clr_o[0] = st_we && !wdata_i[ST_CUR_LOG];
  assign clr_o[1] = st_we && !wdata_i[ST_XDOM_LOG];

  always_comb begin
    en_d = {wdata_i[EN_MIN], wdata_i[EN_CHG]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_chg_o = en_q[0];
  assign en_min_o = en_q[1];

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_STATUS: begin
        rdata_o[ST_CUR_LIVE]  = cur_live_i;
        rdata_o[ST_CUR_LOG]   = log_i[0];
        rdata_o[ST_XDOM_LIVE] = xdom_live_i;
        rdata_o[ST_XDOM_LOG]  = log_i[1];
      end
      default: begin
        rdata_o[EN_CHG] = en_q[0];
        rdata_o[EN_MIN] = en_q[1];
      end
    endcase
  end

  // R6
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_d)));

  // R6
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/perf_limit_logger.sv
module perf_limit_logger
  import plim_pkg::*;
#(
  parameter int unsigned REG_W   = plim_pkg::REG_W,
  parameter int unsigned GPERF_W = plim_pkg::GPERF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur_lim_i,
  input  logic               xdom_lim_i,
  input  logic [GPERF_W-1:0] guar_perf_i,
  input  logic               min_exc_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               irq_ack_i,
  output logic               irq_o
);
  logic             rst_s_n;
  logic [N_LIM-1:0] lim_live;
  logic [N_LIM-1:0] lim_log;
  logic [N_LIM-1:0] lim_clr;
  logic             en_chg;
  logic             en_min;

  assign lim_live = {xdom_lim_i, cur_lim_i};

  plim_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar g = 0; g < N_LIM; g++) begin : g_log
    plim_sticky_log i_log (
      .clk   (clk),
      .rst_n (rst_s_n),
      .set_i (lim_live[g]),
      .clr_i (lim_clr[g]),
      .log_o (lim_log[g])
    );
  end

  plim_regs #(.REG_W(REG_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .wr_i        (reg_wr_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .cur_live_i  (cur_lim_i),
    .xdom_live_i (xdom_lim_i),
    .log_i       (lim_log),
    .clr_o       (lim_clr),
    .en_chg_o    (en_chg),
    .en_min_o    (en_min),
    .rdata_o     (reg_rdata_o)
  );

  plim_irq_ctl #(.GPERF_W(GPERF_W)) i_irq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .gperf_i   (guar_perf_i),
    .en_chg_i  (en_chg),
    .en_min_i  (en_min),
    .min_exc_i (min_exc_i),
    .ack_i     (irq_ack_i),
    .pend_o    (irq_o)
  );

  // R1
  live_bits_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_sel_i == 1'b0) |-> (reg_rdata_o[ST_CUR_LIVE] == cur_lim_i &&
                             reg_rdata_o[ST_XDOM_LIVE] == xdom_lim_i));
endmodule

// File: tb/test_perf_limit_logger.sv
module test_perf_limit_logger;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  // {cur, xdom, wr, w13, w15, exp13, exp15}
  localparam logic [6:0] VEC [12] = '{
    7'b00_0_00_00,
    7'b10_0_00_10,
    7'b00_0_00_10,
    7'b00_1_11_10,
    7'b01_0_00_11,
    7'b00_1_01_01,
    7'b01_1_10_01,
    7'b00_1_10_00,
    7'b11_1_00_11,
    7'b00_0_00_11,
    7'b00_1_00_00,
    7'b00_0_00_00
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cur_lim, xdom_lim, min_exc, reg_wr, reg_sel, irq_ack;
  logic [7:0]  gperf;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_limit_logger i_perf_limit_logger (
    .clk (clk), .rst_n (rst_n), .cur_lim_i (cur_lim), .xdom_lim_i (xdom_lim),
    .guar_perf_i (gperf), .min_exc_i (min_exc), .reg_wr_i (reg_wr),
    .reg_sel_i (reg_sel), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .irq_ack_i (irq_ack), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; wdata = '0;
  endtask

  task automatic read_chk(input string req, input logic sel, input logic [63:0] exp);
    reg_sel = sel; #1;
    chk(req, rdata, exp);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cur_lim = 0; xdom_lim = 0; min_exc = 0; reg_wr = 0; reg_sel = 0;
    irq_ack = 0; gperf = 8'h40; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    read_chk("R11 status after reset", 1'b0, 64'h0);
    read_chk("R11 enables after reset", 1'b1, 64'h0);
    chk("R11 irq after reset", {63'h0, irq}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R2 R3 R4 R5 R1: table of log behaviour
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cur_lim  = VEC[i][6];
      xdom_lim = VEC[i][5];
      reg_wr   = VEC[i][4];
      reg_sel  = 1'b0;
      wdata    = {64{1'b1}};
      wdata[13] = VEC[i][3];
      wdata[15] = VEC[i][2];
      step();
      reg_wr = 1'b0;
      read_chk("R1 R2 R3 R4 R5 status vector", 1'b0,
               64'(({VEC[i][0], VEC[i][5], VEC[i][1], VEC[i][6]}) << 12));
    end
    @(negedge clk); cur_lim = 0; xdom_lim = 0;

    // R6 enable word, reserved bits read 0
    wr_reg(1'b1, {64{1'b1}});
    read_chk("R6 enable all-ones write", 1'b1, 64'h3);
    wr_reg(1'b1, 64'h0);
    read_chk("R6 enable cleared", 1'b1, 64'h0);

    // R8 change while disabled
    @(negedge clk); gperf = 8'h55;
    step();
    step();
    chk("R8 no irq when change disabled", {63'h0, irq}, 64'h0);

    // R7 change while enabled
    wr_reg(1'b1, 64'h1);
    @(negedge clk); gperf = 8'h56;
    step();
    chk("R7 irq after change", {63'h0, irq}, 64'h1);
    repeat (3) step();
    chk("R7 irq holds until ack", {63'h0, irq}, 64'h1);
    @(negedge clk); irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R10 ack clears", {63'h0, irq}, 64'h0);
    // R10 event wins over ack
    @(negedge clk); irq_ack = 1'b1; gperf = 8'h57;
    step();
    irq_ack = 1'b0;
    chk("R10 event beats ack", {63'h0, irq}, 64'h1);
    @(negedge clk); irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R10 ack after event", {63'h0, irq}, 64'h0);

    // R9 minimum excursion, disabled then enabled
    @(negedge clk); min_exc = 1'b1;
    step();
    min_exc = 1'b0;
    chk("R9 pulse ignored when disabled", {63'h0, irq}, 64'h0);
    wr_reg(1'b1, 64'h2);
    @(negedge clk); gperf = 8'h11;
    step();
    step();
    chk("R8 change ignored with only bit1", {63'h0, irq}, 64'h0);
    @(negedge clk); min_exc = 1'b1;
    step();
    min_exc = 1'b0;
    chk("R9 pulse sets irq", {63'h0, irq}, 64'h1);

    // R11 reset mid-run
    @(negedge clk); cur_lim = 1'b1; xdom_lim = 1'b1;
    step();
    @(negedge clk); cur_lim = 1'b0; xdom_lim = 1'b0;
    rst_n = 1'b0;
    #1;
    read_chk("R11 logs cleared by reset", 1'b0, 64'h0);
    read_chk("R11 enables cleared by reset", 1'b1, 64'h0);
    chk("R11 irq cleared by reset", {63'h0, irq}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step();
    read_chk("R11 state after release", 1'b0, 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule